// File: doc/BRIEF.md
# Equaliser Error Monitor with Hysteretic Adaptation Gate

This block watches the decision error of an adaptive equaliser, one signed error word per symbol. It sums the magnitude of every valid error into a saturating accumulator. When a check request rises, that sum is captured and the accumulator starts again from zero. The captured sum is then compared against programmable levels, which gives two status flags, an adaptation enable and a power-of-two gain exponent.

The adaptation enable uses two thresholds, a low one and a high one. It is on after reset and switches off once a captured sum falls under the low threshold. It stays off until a captured sum rises above the high threshold. Coefficient updates therefore run in bursts: they start when the error grows and stop once it has settled. The gain exponent moves down one step at each check where the error is under its own threshold and up one step where it is above. It is always held inside a programmable range.

Top module: `err_mon`

## Requirements
- R1: During and after reset, until the first capture, `upd_en` is 1, `gain_exp` is all ones (the GAIN_RST default), and `cap_val`, `cap_valid`, `below_lo` and `above_hi` are 0.
- R2: Each cycle with `sym_valid`=1 adds the magnitude of the two's-complement `sym_err` to the accumulator. The most negative code counts as 2^(ERR_W-1). Cycles with `sym_valid`=0 add nothing, whatever the error value.
- R3: The accumulator saturates at 2^ACC_W-1 and never wraps.
- R4: A capture happens only at a clock edge where `chk_req` is 1 after being 0 at the previous edge. A request held high makes no further captures. `cap_valid` is 1 for exactly the one cycle after a capture edge.
- R5: At a capture edge `cap_val` takes the accumulator value from before that edge. A valid symbol present in the same cycle is counted into the freshly cleared accumulator and appears in the next capture.
- R6: After a capture, `below_lo` = (`cap_val` < `lo_thr`) and `above_hi` = (`cap_val` > `hi_thr`), using the thresholds sampled at the capture edge.
- R7: If `upd_en` is 1 and a captured value is below `lo_thr`, `upd_en` becomes 0. Otherwise it stays 1.
- R8: If `upd_en` is 0, it becomes 1 only when a captured value exceeds `hi_thr`. A value at or below `hi_thr` leaves it 0.
- R9: At each capture `gain_exp` steps down by one if the captured value is below `gain_thr`, steps up by one if it is above, and holds if it is equal.
- R10: After the step, `gain_exp` is clamped into [`exp_min`, `exp_max`].
- R11: `cap_val`, the flags, `upd_en` and `gain_exp` change only at capture edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol error present this cycle |
| sym_err | input | ERR_W | Signed slicer error |
| chk_req | input | 1 | Check request, acts on its rising edge |
| lo_thr | input | ACC_W | Level under which adaptation stops |
| hi_thr | input | ACC_W | Level over which adaptation restarts |
| gain_thr | input | ACC_W | Level that steers the gain exponent |
| exp_min | input | EXP_W | Lowest allowed gain exponent |
| exp_max | input | EXP_W | Highest allowed gain exponent |
| cap_val | output | ACC_W | Captured error sum |
| cap_valid | output | 1 | One-cycle pulse after a capture |
| below_lo | output | 1 | Captured sum under `lo_thr` |
| above_hi | output | 1 | Captured sum over `hi_thr` |
| upd_en | output | 1 | Coefficient adaptation enable |
| gain_exp | output | EXP_W | Power-of-two gain exponent |

## Verification
The bench builds the block with ERR_W=8, ACC_W=10 and EXP_W=3. With an 8-bit error it can sweep all 256 error codes, each in its own capture window, including the most negative code. A 10-bit sum saturates after eight full-scale symbols, so the clamp is reached quickly. A 3-bit exponent lets the gain walk its whole range and hit both clamp limits. Scripted window sums land exactly on, just under and just over each threshold, to check both edges of the hysteresis.

// File: rtl/err_mon_pkg.sv
package err_mon_pkg;
  typedef enum logic [1:0] {
    GSTEP_HOLD = 2'd0,
    GSTEP_DOWN = 2'd1,
    GSTEP_UP   = 2'd2
  } gstep_e;
endpackage

// File: rtl/err_mon_edge.sv
module err_mon_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/err_mon_acc.sv
module err_mon_acc #(
  parameter int ERR_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [ERR_W-1:0] err,
  input  logic             clear,
  output logic [ACC_W-1:0] acc
);
  localparam int PAD_W = ACC_W - ERR_W;

  logic [ERR_W-1:0] mag;
  logic [ACC_W-1:0] mag_ext;
  logic [ACC_W:0]   sum;

  // two's-complement magnitude; the most negative code maps to 2^(ERR_W-1)
  assign mag     = err[ERR_W-1] ? (~err + 1'b1) : err;
  assign mag_ext = {{PAD_W{1'b0}}, mag};
  assign sum     = {1'b0, acc} + {1'b0, mag_ext};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (clear) begin
      acc <= valid ? mag_ext : '0;
    end else if (valid) begin
      acc <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/err_mon_ctl.sv
module err_mon_ctl
  import err_mon_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int EXP_W = 4,
  parameter logic [EXP_W-1:0] GAIN_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_stb,
  input  logic [ACC_W-1:0] cap_in,
  input  logic [ACC_W-1:0] lo_thr,
  input  logic [ACC_W-1:0] hi_thr,
  input  logic [ACC_W-1:0] gain_thr,
  input  logic [EXP_W-1:0] exp_min,
  input  logic [EXP_W-1:0] exp_max,
  output logic [ACC_W-1:0] cap_val,
  output logic             cap_valid,
  output logic             below_lo,
  output logic             above_hi,
  output logic             upd_en,
  output logic [EXP_W-1:0] gain_exp
);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  gstep_e           step;
  logic [EXP_W-1:0] g_step;
  logic [EXP_W-1:0] g_nxt;
  logic             upd_nxt;

  always_comb begin
    if (cap_in < gain_thr)      step = GSTEP_DOWN;
    else if (cap_in > gain_thr) step = GSTEP_UP;
    else                        step = GSTEP_HOLD;

    case (step)
      GSTEP_DOWN: g_step = (gain_exp != '0)      ? gain_exp - 1'b1 : gain_exp;
      GSTEP_UP:   g_step = (gain_exp != EXP_TOP) ? gain_exp + 1'b1 : gain_exp;
      default:    g_step = gain_exp;
    endcase

    if (g_step < exp_min)      g_nxt = exp_min;
    else if (g_step > exp_max) g_nxt = exp_max;
    else                       g_nxt = g_step;

    // hysteresis: leave on until under low, leave off until over high
    upd_nxt = upd_en ? (cap_in >= lo_thr) : (cap_in > hi_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val   <= '0;
      cap_valid <= 1'b0;
      below_lo  <= 1'b0;
      above_hi  <= 1'b0;
      upd_en    <= 1'b1;
      gain_exp  <= GAIN_RST;
    end else begin
      cap_valid <= cap_stb;
      if (cap_stb) begin
        cap_val  <= cap_in;
        below_lo <= (cap_in < lo_thr);
        above_hi <= (cap_in > hi_thr);
        upd_en   <= upd_nxt;
        gain_exp <= g_nxt;
      end
    end
  end
endmodule

// File: rtl/err_mon.sv
module err_mon #(
  parameter int ERR_W = 8,
  parameter int ACC_W = 16,
  parameter int EXP_W = 4,
  parameter logic [EXP_W-1:0] GAIN_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [ERR_W-1:0] sym_err,
  input  logic             chk_req,
  input  logic [ACC_W-1:0] lo_thr,
  input  logic [ACC_W-1:0] hi_thr,
  input  logic [ACC_W-1:0] gain_thr,
  input  logic [EXP_W-1:0] exp_min,
  input  logic [EXP_W-1:0] exp_max,
  output logic [ACC_W-1:0] cap_val,
  output logic             cap_valid,
  output logic             below_lo,
  output logic             above_hi,
  output logic             upd_en,
  output logic [EXP_W-1:0] gain_exp
);
  logic             cap_stb;
  logic [ACC_W-1:0] acc;

  err_mon_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (chk_req),
    .rise (cap_stb)
  );

  err_mon_acc #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .valid (sym_valid),
    .err   (sym_err),
    .clear (cap_stb),
    .acc   (acc)
  );

  err_mon_ctl #(.ACC_W(ACC_W), .EXP_W(EXP_W), .GAIN_RST(GAIN_RST)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cap_stb   (cap_stb),
    .cap_in    (acc),
    .lo_thr    (lo_thr),
    .hi_thr    (hi_thr),
    .gain_thr  (gain_thr),
    .exp_min   (exp_min),
    .exp_max   (exp_max),
    .cap_val   (cap_val),
    .cap_valid (cap_valid),
    .below_lo  (below_lo),
    .above_hi  (above_hi),
    .upd_en    (upd_en),
    .gain_exp  (gain_exp)
  );
endmodule

// File: rtl/err_mon_chk.sv
module err_mon_chk #(
  parameter int ACC_W = 16,
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             chk_req,
  input logic [ACC_W-1:0] lo_thr,
  input logic [ACC_W-1:0] hi_thr,
  input logic [EXP_W-1:0] exp_min,
  input logic [EXP_W-1:0] exp_max,
  input logic [ACC_W-1:0] cap_val,
  input logic             cap_valid,
  input logic             below_lo,
  input logic             above_hi,
  input logic             upd_en,
  input logic [EXP_W-1:0] gain_exp
);
  assert_upd_on_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> upd_en);

  assert_capture_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> ($past(chk_req) && !$past(chk_req, 2)));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> !cap_valid);

  assert_flags_R6: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (below_lo == (cap_val < $past(lo_thr))) &&
                  (above_hi == (cap_val > $past(hi_thr))));

  assert_stay_on_R7: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && $past(upd_en) && (cap_val >= $past(lo_thr))) |-> upd_en);

  assert_stay_off_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && !$past(upd_en) && (cap_val <= $past(hi_thr))) |-> !upd_en);

  assert_gain_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    (cap_valid && ($past(exp_min) <= $past(exp_max))) |->
      (gain_exp >= $past(exp_min)) && (gain_exp <= $past(exp_max)));

  assert_hold_between_R11: assert property (@(posedge clk) disable iff (rst)
    !cap_valid |-> ($stable(upd_en) && $stable(gain_exp) && $stable(cap_val) &&
                    $stable(below_lo) && $stable(above_hi)));
endmodule

bind err_mon err_mon_chk #(.ACC_W(ACC_W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_req   (chk_req),
  .lo_thr    (lo_thr),
  .hi_thr    (hi_thr),
  .exp_min   (exp_min),
  .exp_max   (exp_max),
  .cap_val   (cap_val),
  .cap_valid (cap_valid),
  .below_lo  (below_lo),
  .above_hi  (above_hi),
  .upd_en    (upd_en),
  .gain_exp  (gain_exp)
);

// File: tb/sim_err_mon.sv
module sim_err_mon;
  localparam int ERR_W = 8;
  localparam int ACC_W = 10;
  localparam int EXP_W = 3;
  localparam int SAT   = (1 << ACC_W) - 1;
  localparam int GTOP  = (1 << EXP_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sym_valid = 1'b0;
  logic [ERR_W-1:0] sym_err = '0;
  logic             chk_req = 1'b0;
  logic [ACC_W-1:0] lo_thr = '0;
  logic [ACC_W-1:0] hi_thr = '1;
  logic [ACC_W-1:0] gain_thr = '0;
  logic [EXP_W-1:0] exp_min = '0;
  logic [EXP_W-1:0] exp_max = '1;
  logic [ACC_W-1:0] cap_val;
  logic             cap_valid;
  logic             below_lo;
  logic             above_hi;
  logic             upd_en;
  logic [EXP_W-1:0] gain_exp;

  int n_chk = 0;
  int n_err = 0;
  int macc = 0;
  int mupd = 1;
  int mg = GTOP;
  int mcap = 0;
  int mlo = 0, mhi = SAT, mgt = 0, mmin = 0, mmax = GTOP;

  always #2 clk = ~clk;

  err_mon #(.ERR_W(ERR_W), .ACC_W(ACC_W), .EXP_W(EXP_W)) u0 (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_err(sym_err),
    .chk_req(chk_req), .lo_thr(lo_thr), .hi_thr(hi_thr), .gain_thr(gain_thr),
    .exp_min(exp_min), .exp_max(exp_max), .cap_val(cap_val), .cap_valid(cap_valid),
    .below_lo(below_lo), .above_hi(above_hi), .upd_en(upd_en), .gain_exp(gain_exp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mag(input int e);
    return (e < 0) ? -e : e;
  endfunction

  task automatic set_thr(input int lo, input int hi, input int gt, input int mn, input int mx);
    @(negedge clk);
    lo_thr = lo[ACC_W-1:0]; hi_thr = hi[ACC_W-1:0]; gain_thr = gt[ACC_W-1:0];
    exp_min = mn[EXP_W-1:0]; exp_max = mx[EXP_W-1:0];
    mlo = lo; mhi = hi; mgt = gt; mmin = mn; mmax = mx;
  endtask

  task automatic sym(input bit v, input int e);
    @(negedge clk);
    sym_valid = v; sym_err = e[ERR_W-1:0]; chk_req = 1'b0;
    if (v) begin
      macc = macc + mag(e);
      if (macc > SAT) macc = SAT;
    end
  endtask

  // model of one capture, following the requirements
  task automatic model_capture(input bit v, input int e);
    int g;
    mcap = macc;
    macc = v ? mag(e) : 0;
    if (mupd == 1 && mcap < mlo) mupd = 0;
    else if (mupd == 0 && mcap > mhi) mupd = 1;
    g = mg;
    if (mcap < mgt) begin if (g > 0) g--; end
    else if (mcap > mgt) begin if (g < GTOP) g++; end
    if (g < mmin) g = mmin;
    if (g > mmax) g = mmax;
    mg = g;
  endtask

  task automatic check_outs(input string tag);
    check(cap_valid === 1'b1, {tag, " R4 cap_valid"}, int'(cap_valid), 1);
    check(cap_val == mcap[ACC_W-1:0], {tag, " cap_val"}, int'(cap_val), mcap);
    check(below_lo == (mcap < mlo), {tag, " R6 below_lo"}, int'(below_lo), int'(mcap < mlo));
    check(above_hi == (mcap > mhi), {tag, " R6 above_hi"}, int'(above_hi), int'(mcap > mhi));
    check(upd_en == mupd[0], {tag, " R7/R8 upd_en"}, int'(upd_en), mupd);
    check(gain_exp == mg[EXP_W-1:0], {tag, " R9/R10 gain_exp"}, int'(gain_exp), mg);
  endtask

  task automatic capture(input bit v, input int e, input string tag);
    @(negedge clk);
    chk_req = 1'b1; sym_valid = v; sym_err = e[ERR_W-1:0];
    model_capture(v, e);
    @(negedge clk);
    check_outs(tag);
    chk_req = 1'b0; sym_valid = 1'b0;
  endtask

  // load a window whose magnitude sum equals s, then capture it
  task automatic window(input int s, input string tag);
    int r;
    r = s;
    while (r > 0) begin
      if (r >= 100) begin sym(1'b1, -100); r -= 100; end
      else begin sym(1'b1, r); r = 0; end
    end
    capture(1'b0, 0, tag);
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(upd_en === 1'b1, "R1 upd_en during reset", int'(upd_en), 1);
    rst = 1'b0;
    @(negedge clk);
    check(upd_en === 1'b1 && cap_valid === 1'b0 && below_lo === 1'b0 && above_hi === 1'b0,
          "R1 flags after reset", int'({upd_en, cap_valid, below_lo, above_hi}), 8);
    check(gain_exp == GTOP[EXP_W-1:0], "R1 gain_exp", int'(gain_exp), GTOP);
    check(cap_val == '0, "R1 cap_val", int'(cap_val), 0);

    // R2: every error code, one window each
    set_thr(0, SAT, 0, 0, GTOP);
    for (int e = -(1 << (ERR_W - 1)); e < (1 << (ERR_W - 1)); e++) begin
      sym(1'b1, e);
      capture(1'b0, 0, "R2 sweep");
    end

    // R2: invalid symbols ignored
    sym(1'b1, 10); sym(1'b0, -100); sym(1'b0, 127); sym(1'b1, -5);
    capture(1'b0, 0, "R2 invalid ignored");

    // R3: saturation
    for (int i = 0; i < 10; i++) sym(1'b1, -128);
    capture(1'b0, 0, "R3 saturate");

    // R5: symbol in capture cycle goes to next window
    sym(1'b1, 20);
    capture(1'b1, -7, "R5 first");
    capture(1'b0, 0, "R5 second");

    // R4 / R11: held request gives no new capture
    sym(1'b1, 5);
    capture(1'b1, 9, "R4 rise");
    chk_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sym_valid = 1'b1; sym_err = 8'd40;
      macc = macc + 40;
      @(negedge clk);
      check(cap_valid === 1'b0, "R4 held no recapture", int'(cap_valid), 0);
      check(cap_val == mcap[ACC_W-1:0], "R11 cap_val held", int'(cap_val), mcap);
      check(upd_en == mupd[0] && gain_exp == mg[EXP_W-1:0], "R11 state held",
            int'({upd_en, gain_exp}), mupd * 8 + mg);
    end
    chk_req = 1'b0; sym_valid = 1'b0;
    capture(1'b0, 0, "R4 after release");

    // R7 / R8: hysteresis
    set_thr(100, 300, 0, 0, GTOP);
    if (mupd == 0) window(400, "R8 prime on");
    window(150, "R7 stay on");
    window(100, "R7 equal lo stays on");
    window(99, "R7 off");
    window(200, "R8 stay off");
    window(300, "R8 equal hi stays off");
    window(301, "R8 on");
    window(50, "R7 off again");

    // R9 / R10: gain stepping and clamp
    set_thr(0, SAT, 200, 2, 5);
    for (int i = 0; i < 5; i++) window(50, "R9 R10 step down");
    window(200, "R9 hold at equal");
    for (int i = 0; i < 5; i++) window(250, "R9 R10 step up");
    set_thr(0, SAT, 200, 3, 3);
    window(0, "R10 forced range");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule